// File: doc/BRIEF.md
# Four-Channel DMA Control Register File

This block is the software-facing register front end of a four-channel DMA controller. A processor reaches it over a plain 32-bit register bus that carries a write strobe, a read strobe and a word index. It holds a master enable, a three-bit protection attribute, the base pointer of the descriptor table and a status word. It also holds two per-channel bit banks: one for channel enable and one for selecting between the primary and the alternate descriptor. Each bank is changed only through a write-one-to-set register and a write-one-to-clear register, so software never has to read, modify and write the bank back.

The block drives the transfer engines directly. Each channel gets its enable, its descriptor-bank select and the byte address of its active descriptor. That address is computed from the aligned base, the bank select and the channel index. Software requests leave as single-cycle pulses and are masked while the master enable is off. The engines' done and active strobes are registered and gated by the channel enable to form per-channel interrupt outputs. The engines' raw state code can be read through the status word.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset the master enable, protection field, base pointer, alignment flag, all channel enables, all bank selects (primary), all request pulses, both interrupt vectors and the read data are zero.
- R2: A write to word 3 (enable-set) sets every channel enable whose data bit n is 1 and leaves the others unchanged. A read of word 3 returns the enable vector in bits 3:0.
- R3: A write to word 4 (enable-clear) clears every channel enable whose data bit n is 1 and leaves the others unchanged. Word 4 reads as zero.
- R4: A write of 1 at bit n of word 5 selects the alternate descriptor for channel n, and a write of 1 at bit n of word 6 selects the primary descriptor. Zero bits change nothing. Word 5 reads back the select vector and word 6 reads as zero.
- R5: The descriptor address of channel n is base + 16·n when the primary descriptor is selected and base + 64 + 16·n when the alternate is selected.
- R6: A write to word 1 stores the base pointer with bits 6:0 forced to zero. A read of word 1 returns the stored value.
- R7: A write to word 1 with any of bits 6:0 nonzero sets a sticky alignment flag, read at bit 8 of word 2. Writing word 2 with bit 8 set clears the flag.
- R8: A write to word 7 with the master enable on produces, in the next cycle only, a one-cycle pulse on each channel request whose data bit is 1. Word 7 reads as zero.
- R9: While the master enable is off, a write to word 7 produces no request pulse.
- R10: Word 0 holds the master enable in bit 0 and the protection field in bits 6:4, with bit 4 privileged, bit 5 bufferable and bit 6 cacheable. Both are driven on their outputs and read back.
- R11: Bits 3:0 of a read of word 2 carry the engine state input as sampled at the read.
- R12: Each interrupt output bit n is the matching engine done or active input registered one cycle, and it stays zero while channel n is disabled.
- R13: Read data appears one cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen_i | input | 1 | Register write strobe |
| bus_ren_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| master_en_o | output | 1 | Master enable |
| prot_o | output | 3 | Protection attribute: privileged, bufferable, cacheable |
| chan_en_o | output | 4 | Per-channel enable |
| chan_alt_o | output | 4 | Per-channel alternate-descriptor select |
| desc_addr_o | output | 128 | Active descriptor address, 32 bits per channel, channel 0 lowest |
| req_pulse_o | output | 4 | One-cycle software request per channel |
| eng_state_i | input | 4 | Raw engine state code |
| eng_done_i | input | 4 | Engine done strobes |
| eng_active_i | input | 4 | Engine active strobes |
| irq_done_o | output | 4 | Done interrupt per channel |
| irq_active_o | output | 4 | Active interrupt per channel |

## Verification
The assertions assume that the bus never asserts a read and a write in the same cycle and that every strobe is a clean 0 or 1 from reset onward. They also assume that a request pulse can only come from a write to word 7. The bench drives one transaction at a time on falling edges, holds both strobes low otherwise, and reads results one edge later. It sweeps all 16 set patterns against all 16 clear patterns for each bank, and covers base values with and without low-bit garbage under both bank selects.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    typedef enum logic [2:0] {
        REG_CTRL    = 3'd0,
        REG_BASE    = 3'd1,
        REG_STAT    = 3'd2,
        REG_EN_SET  = 3'd3,
        REG_EN_CLR  = 3'd4,
        REG_ALT_SET = 3'd5,
        REG_ALT_CLR = 3'd6,
        REG_SWREQ   = 3'd7
    } dcr_reg_e;

    typedef struct packed {
        logic        master_en;
        logic [2:0]  prot;
        logic [31:0] base;
        logic        align_err;
        logic [31:0] rdata;
    } dcr_state_t;

endpackage

// File: rtl/dcr_bitbank.sv
module dcr_bitbank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] bits_o
);
    logic [N-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = (bits_q | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits_o = bits_q;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i != '0) && (clr_i == '0)) |=> ((bits_o & $past(set_i)) == $past(set_i))); // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((bits_o & $past(clr_i)) == '0)); // R3
    AST_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i == '0) && (clr_i == '0)) |=> $stable(bits_o)); // R4
endmodule

// File: rtl/dcr_desc_addr.sv
module dcr_desc_addr #(
    parameter int NCH        = 4,
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [NCH-1:0]        alt_i,
    output logic [NCH*ADDR_W-1:0] addr_o
);
    localparam int BANK_BYTES = NCH * DESC_BYTES;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [ADDR_W-1:0] bank_ofs;
        always_comb begin
            bank_ofs = alt_i[ch] ? ADDR_W'(BANK_BYTES) : '0;
            addr_o[ch*ADDR_W +: ADDR_W] = base_i + bank_ofs + ADDR_W'(ch * DESC_BYTES);
        end
    end
endmodule

// File: rtl/dcr_irq_gate.sv
module dcr_irq_gate #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] en_i,
    input  logic [NCH-1:0] done_i,
    input  logic [NCH-1:0] active_i,
    output logic [NCH-1:0] irq_done_o,
    output logic [NCH-1:0] irq_active_o
);
    logic [NCH-1:0] done_d, done_q, act_d, act_q;

    always_comb begin
        done_d = done_i & en_i;
        act_d  = active_i & en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= '0;
            act_q  <= '0;
        end else begin
            done_q <= done_d;
            act_q  <= act_d;
        end
    end

    assign irq_done_o   = done_q;
    assign irq_active_o = act_q;

    AST_IRQ_DONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_done_o & ~$past(en_i)) == '0)); // R12
    AST_IRQ_ACT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_active_o & ~$past(en_i)) == '0)); // R12
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
    import dcr_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int DESC_BYTES = 16,
    parameter int STATE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen_i,
    input  logic              bus_ren_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              master_en_o,
    output logic [2:0]        prot_o,
    output logic [NCH-1:0]    chan_en_o,
    output logic [NCH-1:0]    chan_alt_o,
    output logic [NCH*32-1:0] desc_addr_o,
    output logic [NCH-1:0]    req_pulse_o,
    input  logic [STATE_W-1:0] eng_state_i,
    input  logic [NCH-1:0]    eng_done_i,
    input  logic [NCH-1:0]    eng_active_i,
    output logic [NCH-1:0]    irq_done_o,
    output logic [NCH-1:0]    irq_active_o
);
    localparam int ALIGN_BITS = $clog2(2 * NCH * DESC_BYTES);
    localparam int PROT_LSB   = 4;
    localparam int FLAG_BIT   = 8;

    dcr_state_t     st_d, st_q;
    logic [NCH-1:0] req_d, req_q;
    logic [NCH-1:0] en_set, en_clr, alt_set, alt_clr;
    logic [NCH-1:0] en_bits, alt_bits;

    function automatic logic hit(input dcr_reg_e r);
        return bus_wen_i && (bus_addr_i == r);
    endfunction

    always_comb begin
        en_set  = hit(REG_EN_SET)  ? bus_wdata_i[NCH-1:0] : '0;
        en_clr  = hit(REG_EN_CLR)  ? bus_wdata_i[NCH-1:0] : '0;
        alt_set = hit(REG_ALT_SET) ? bus_wdata_i[NCH-1:0] : '0;
        alt_clr = hit(REG_ALT_CLR) ? bus_wdata_i[NCH-1:0] : '0;
    end

    always_comb begin
        st_d  = st_q;
        req_d = '0;
        if (hit(REG_CTRL)) begin
            st_d.master_en = bus_wdata_i[0];
            st_d.prot      = bus_wdata_i[PROT_LSB +: 3];
        end
        if (hit(REG_BASE)) begin
            st_d.base = {bus_wdata_i[31:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            if (bus_wdata_i[ALIGN_BITS-1:0] != '0) st_d.align_err = 1'b1;
        end
        if (hit(REG_STAT) && bus_wdata_i[FLAG_BIT]) st_d.align_err = 1'b0;
        if (hit(REG_SWREQ) && st_q.master_en) req_d = bus_wdata_i[NCH-1:0];
        if (bus_ren_i) begin
            case (dcr_reg_e'(bus_addr_i))
                REG_CTRL:    st_d.rdata = 32'(st_q.master_en) | (32'(st_q.prot) << PROT_LSB);
                REG_BASE:    st_d.rdata = st_q.base;
                REG_STAT:    st_d.rdata = 32'(eng_state_i) | (32'(st_q.align_err) << FLAG_BIT);
                REG_EN_SET:  st_d.rdata = 32'(en_bits);
                REG_ALT_SET: st_d.rdata = 32'(alt_bits);
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            req_q <= '0;
        end else begin
            st_q  <= st_d;
            req_q <= req_d;
        end
    end

    dcr_bitbank #(.N(NCH)) u_en_bank (
        .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr), .bits_o(en_bits)
    );

    dcr_bitbank #(.N(NCH)) u_alt_bank (
        .clk(clk), .rst_n(rst_n), .set_i(alt_set), .clr_i(alt_clr), .bits_o(alt_bits)
    );

    dcr_desc_addr #(.NCH(NCH), .ADDR_W(32), .DESC_BYTES(DESC_BYTES)) u_addr (
        .base_i(st_q.base), .alt_i(alt_bits), .addr_o(desc_addr_o)
    );

    dcr_irq_gate #(.NCH(NCH)) u_irq (
        .clk(clk), .rst_n(rst_n), .en_i(en_bits), .done_i(eng_done_i),
        .active_i(eng_active_i), .irq_done_o(irq_done_o), .irq_active_o(irq_active_o)
    );

    assign bus_rdata_o = st_q.rdata;
    assign master_en_o = st_q.master_en;
    assign prot_o      = st_q.prot;
    assign chan_en_o   = en_bits;
    assign chan_alt_o  = alt_bits;
    assign req_pulse_o = req_q;

    AST_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pulse_o != '0) |-> $past(master_en_o)); // R9
    AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pulse_o != '0) |-> $past(bus_wen_i && (bus_addr_i == REG_SWREQ))); // R8
    AST_ALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen_i && (bus_addr_i == REG_BASE) && (bus_wdata_i[ALIGN_BITS-1:0] != '0))
        |=> st_q.align_err); // R7
    AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_alt_o[0] |-> (desc_addr_o[ALIGN_BITS-1:0] == '0)); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ren_i |=> $stable(bus_rdata_o)); // R13
endmodule

// File: tb/dma_chan_regfile_bench.sv
module dma_chan_regfile_bench;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wen = 1'b0, ren = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        men;
    logic [2:0]  prot;
    logic [3:0]  en, alt, req, irqd, irqa;
    logic [127:0] daddr;
    logic [3:0]  state = '0, edone = '0, eact = '0;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_chan_regfile u_dma_chan_regfile (
        .clk(clk), .rst_n(rst_n), .bus_wen_i(wen), .bus_ren_i(ren), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .master_en_o(men), .prot_o(prot),
        .chan_en_o(en), .chan_alt_o(alt), .desc_addr_o(daddr), .req_pulse_o(req),
        .eng_state_i(state), .eng_done_i(edone), .eng_active_i(eact),
        .irq_done_o(irqd), .irq_active_o(irqa)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wen = 1'b1; addr = a; wdata = d;
        @(negedge clk); wen = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); ren = 1'b1; addr = a;
        @(negedge clk); ren = 1'b0; v = rdata;
    endtask

    task automatic chk_addr(input string r, input logic [31:0] base);
        for (int n = 0; n < NCH; n++)
            chk(r, daddr[n*32 +: 32], base + (alt[n] ? 32'd64 : 32'd0) + 32'(16 * n));
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 en", 32'(en), 0); chk("R1 alt", 32'(alt), 0); chk("R1 men", 32'(men), 0);
        chk("R1 prot", 32'(prot), 0); chk("R1 req", 32'(req), 0); chk("R1 rdata", rdata, 0);
        chk("R1 irq", 32'({irqd, irqa}), 0); chk("R1 addr0", daddr[31:0], 0);

        // R10 control word
        wr(3'd0, 32'h51);
        chk("R10 men", 32'(men), 1); chk("R10 prot", 32'(prot), 32'h5);
        rd(3'd0, v); chk("R10 read", v, 32'h51);
        wr(3'd0, 32'h61); rd(3'd0, v); chk("R10 read2", v, 32'h61);

        // R2 R3 full sweep of set vs clear patterns
        for (int p = 0; p < 16; p++) begin
            for (int q = 0; q < 16; q++) begin
                wr(3'd4, 32'hF);
                wr(3'd3, 32'(p));
                chk("R2 set", 32'(en), 32'(p));
                wr(3'd4, 32'(q));
                chk("R3 clr", 32'(en), 32'(p & ~q & 4'hF));
            end
            rd(3'd3, v); chk("R2 readback", v, 32'(p & 4'h0));
        end
        wr(3'd3, 32'hA); rd(3'd3, v); chk("R2 read", v, 32'hA);
        wr(3'd3, 32'h0); chk("R2 zero no effect", 32'(en), 32'hA);
        rd(3'd4, v); chk("R3 reads zero", v, 0);

        // R6 R7 base pointer
        wr(3'd1, 32'h2000_0080);
        rd(3'd1, v); chk("R6 base", v, 32'h2000_0080);
        rd(3'd2, v); chk("R7 no flag", v[8] ? 32'd1 : 32'd0, 0);
        wr(3'd1, 32'h1234_56FF);
        rd(3'd1, v); chk("R6 masked", v, 32'h1234_5680);
        rd(3'd2, v); chk("R7 flag set", 32'(v[8]), 1);
        wr(3'd1, 32'h4000_0000);
        rd(3'd2, v); chk("R7 sticky", 32'(v[8]), 1);
        wr(3'd2, 32'h100);
        rd(3'd2, v); chk("R7 cleared", 32'(v[8]), 0);

        // R4 R5 alternate sweep with descriptor addresses
        for (int p = 0; p < 16; p++) begin
            for (int q = 0; q < 16; q++) begin
                wr(3'd6, 32'hF);
                wr(3'd5, 32'(p));
                chk("R4 altset", 32'(alt), 32'(p));
                chk_addr("R5 addr", 32'h4000_0000);
                wr(3'd6, 32'(q));
                chk("R4 altclr", 32'(alt), 32'(p & ~q & 4'hF));
                chk_addr("R5 addr", 32'h4000_0000);
            end
        end
        wr(3'd5, 32'h6); rd(3'd5, v); chk("R4 read", v, 32'h6);
        rd(3'd6, v); chk("R4 clr reads zero", v, 0);
        wr(3'd1, 32'hFFFF_FF80); chk_addr("R5 high base", 32'hFFFF_FF80);

        // R8 R9 software requests
        wr(3'd0, 32'h1);
        for (int p = 0; p < 16; p++) begin
            wr(3'd7, 32'(p));
            chk("R8 pulse", 32'(req), 32'(p));
            @(negedge clk);
            chk("R8 one cycle", 32'(req), 0);
        end
        rd(3'd7, v); chk("R8 reads zero", v, 0);
        wr(3'd0, 32'h0);
        for (int p = 1; p < 16; p++) begin
            wr(3'd7, 32'(p));
            chk("R9 masked", 32'(req), 0);
        end

        // R11 state, R13 hold
        state = 4'hA;
        wr(3'd2, 32'h100);
        rd(3'd2, v); chk("R11 state", v, 32'hA);
        state = 4'h3;
        repeat (3) @(negedge clk);
        chk("R13 hold", rdata, 32'hA);

        // R12 interrupts
        wr(3'd4, 32'hF); wr(3'd3, 32'h5);
        @(negedge clk); edone = 4'hF; eact = 4'h3;
        @(negedge clk); edone = '0; eact = '0;
        chk("R12 done", 32'(irqd), 32'h5); chk("R12 active", 32'(irqa), 32'h1);
        @(negedge clk);
        chk("R12 done drop", 32'(irqd), 0); chk("R12 active drop", 32'(irqa), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule